// File: doc/BRIEF.md
# Root Hub Port Status and Control Registers

This block holds the per-port status and control word of a full-speed/low-speed host controller's root hub, one 16-bit register for each downstream port (two by default). Software reaches the words through a small register window: a write updates the control fields of the addressed port, a read returns its full status word one cycle later. The physical-layer logic reports device arrival and removal as single-cycle attach and detach events, and the attach event carries a flag that marks a low-speed device.

The block keeps the connection, enable, speed and reset state of each port. It records connection and enable changes in sticky change flags, which software clears by writing 1 to them. It produces two kinds of one-cycle pulse. The first is a port reset request toward the attached device, raised only when software moves the reset control from 0 to 1. The second is a resume request toward the controller core, raised whenever an attach or detach event arrives. Line-state sensing and bus signalling belong to other blocks.

Top module: `root_port_regs`

## Requirements
- R1: After synchronous active-low reset every port word reads 0x0080, and `rd_data`, `dev_reset_req` and `resume_req` are all zero.
- R2: A write to a port keeps the stored value of the bits in mask 0x01FB (bits 0, 1, 3 to 8) and loads every other bit (enable bit 2, reset bit 9, bits 15:10) from `wr_data`.
- R3: Writing 1 to connect-change (bit 1) or enable-change (bit 3) clears that bit. Writing 0 to either bit leaves it unchanged.
- R4: `dev_reset_req[p]` pulses for exactly one cycle, in the cycle after a write to port p. The pulse happens only when that write sets bit 9 to 1 while the stored bit 9 is 0.
- R5: An attach event sets connected (bit 0) and connect-change (bit 1), and sets low-speed (bit 8) to the value of `attach_low_speed`.
- R6: A detach event on a connected port clears bit 0 and sets bit 1. If the port is enabled (bit 2), the same event also clears bit 2 and sets bit 3. On a port that is not connected and not enabled, a detach leaves all bits unchanged.
- R7: `resume_req` is high for one cycle, in the cycle after any attach or detach event, and is not high at any other time.
- R8: A port word is selected when `reg_addr[4]` is 1, and the port index is `reg_addr[3:1]`. `reg_addr[0]` is ignored. If `reg_addr[4]` is 0 or the index is not below the number of ports, a write changes nothing and a read returns 0xFF7F.
- R9: `rd_data` is registered. After a read, it shows the word as it was before any write in the same cycle. It keeps its value in cycles without a read.
- R10: When an event and a write reach the same port in the same cycle, the event is applied on top of the written value. When an attach and a detach reach the same port in the same cycle, the attach wins and the detach is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register window address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |
| attach_valid | input | 1 | Device attach event |
| attach_port | input | 1 | Port index of the attach event |
| attach_low_speed | input | 1 | Attached device is low speed |
| detach_valid | input | 1 | Device detach event |
| detach_port | input | 1 | Port index of the detach event |
| dev_reset_req | output | 2 | Per-port reset request pulse toward the device |
| resume_req | output | 1 | Resume request pulse toward the controller core |

## Verification
Some behaviour is checked by the assertions on every cycle. These cover the preserve-and-load split of a plain write, the write-1-to-clear of the change bits, the effect of isolated attach and detach events, the single-cycle shape of both request pulses, the default read of unmapped addresses and the holding of `rd_data`. The bench's scenarios are needed for the rest. They cover the reset word, the exact read-before-write ordering, the repeated reset control written with 1 that must not pulse again, and the priority when a write, an attach and a detach reach the same port together. A behavioural reference model, compared on every clock under random traffic, covers the combinations that no scenario names.

// File: rtl/rh_port_pkg.sv
// Package: shared constants and types for the root hub port registers.
// Assumes 16-bit port words. Bit positions are fixed by the register layout.
package rh_port_pkg;

    localparam int WORD_W = 16;

    // Bit positions inside a port word
    localparam int B_CONN     = 0;
    localparam int B_CONN_CHG = 1;
    localparam int B_EN       = 2;
    localparam int B_EN_CHG   = 3;
    localparam int B_LOWSPD   = 8;
    localparam int B_PRST     = 9;

    localparam logic [WORD_W-1:0] KEEP_MASK    = 16'h01FB;
    localparam logic [WORD_W-1:0] WORD_RESET   = 16'h0080;
    localparam logic [WORD_W-1:0] READ_DEFAULT = 16'hFF7F;

    // Per-port view of the attach/detach event inputs
    typedef struct packed {
        logic attach;
        logic detach;
        logic low_speed;
    } port_evt_t;

endpackage

// File: rtl/rh_addr_decode.sv
// Module: turns the register window address into per-port write selects
// and a read index. Assumes the port region is flagged by the top address
// bit, the index sits in bits [3:1], and bit 0 is ignored.
module rh_addr_decode
    import rh_port_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 5,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 wr_en,
    output logic [NUM_PORTS-1:0] wr_sel,
    output logic                 addr_hit,
    output logic [IDX_W-1:0]     addr_idx
);

    localparam int FIELD_W = ADDR_W - 2;

    logic [FIELD_W-1:0] field;

    // Extract the index field and check it against the port count
    always_comb begin
        field    = reg_addr[ADDR_W-2:1];
        addr_hit = reg_addr[ADDR_W-1] && (int'(field) < NUM_PORTS);
        addr_idx = field[IDX_W-1:0];
    end

    // One write select per port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
        assign wr_sel[p] = wr_en && addr_hit && (addr_idx == IDX_W'(p));
    end

    // R8: at most one port is written per cycle
    p_wr_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R8: an address outside the port region selects nothing
    p_no_sel_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr[ADDR_W-1] |-> (wr_sel == '0));

endmodule

// File: rtl/rh_event_route.sv
// Module: routes attach/detach events to per-port event records and forms
// the resume request. Assumes events are single-cycle strobes.
module rh_event_route
    import rh_port_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 attach_valid,
    input  logic [IDX_W-1:0]     attach_port,
    input  logic                 attach_low_speed,
    input  logic                 detach_valid,
    input  logic [IDX_W-1:0]     detach_port,
    output port_evt_t            evt [NUM_PORTS],
    output logic                 resume_req
);

    logic [NUM_PORTS-1:0] att_vec;

    // Fan each event out to the port it names
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_route
        always_comb begin
            evt[p].attach    = attach_valid && (attach_port == IDX_W'(p));
            evt[p].detach    = detach_valid && (detach_port == IDX_W'(p));
            evt[p].low_speed = attach_low_speed;
            att_vec[p]       = evt[p].attach;
        end
    end

    // Register the resume pulse one cycle after any event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_req <= 1'b0;
        end else begin
            resume_req <= attach_valid || detach_valid;
        end
    end

    // R7: every event is followed by a resume pulse
    p_resume_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (attach_valid || detach_valid) |=> resume_req);

    // R7: no resume pulse without an event
    p_resume_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> $past(attach_valid || detach_valid));

    // R10: an attach event reaches one port at most
    p_attach_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(att_vec));

endmodule

// File: rtl/rh_port_cell.sv
// Module: one port's status/control word. Applies a register write first,
// then any attach/detach event on top. Attach wins over detach. Assumes
// wr_sel and the events are one-cycle strobes.
module rh_port_cell
    import rh_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  port_evt_t         evt,
    output logic [WORD_W-1:0] word_q,
    output logic              dev_rst_q
);

    localparam logic [WORD_W-1:0] CHG_BITS =
        (WORD_W'(1) << B_CONN_CHG) | (WORD_W'(1) << B_EN_CHG);

    logic [WORD_W-1:0] after_wr;
    logic [WORD_W-1:0] word_d;
    logic              dev_rst_d;

    // Write stage: keep masked bits, load the rest, clear change bits on 1
    always_comb begin
        after_wr = word_q;
        if (wr_sel) begin
            after_wr = (word_q & KEEP_MASK) | (wr_data & ~KEEP_MASK);
            if (wr_data[B_CONN_CHG]) after_wr[B_CONN_CHG] = 1'b0;
            if (wr_data[B_EN_CHG])   after_wr[B_EN_CHG]   = 1'b0;
        end
    end

    // Event stage: attach or detach updates on top of the write result
    always_comb begin
        word_d = after_wr;
        if (evt.attach) begin
            word_d[B_CONN]     = 1'b1;
            word_d[B_CONN_CHG] = 1'b1;
            word_d[B_LOWSPD]   = evt.low_speed;
        end else if (evt.detach) begin
            if (after_wr[B_CONN]) begin
                word_d[B_CONN]     = 1'b0;
                word_d[B_CONN_CHG] = 1'b1;
            end
            if (after_wr[B_EN]) begin
                word_d[B_EN]     = 1'b0;
                word_d[B_EN_CHG] = 1'b1;
            end
        end
    end

    // Reset request only when the reset control goes from 0 to 1
    always_comb begin
        dev_rst_d = wr_sel && wr_data[B_PRST] && !word_q[B_PRST];
    end

    // State register for the word and the reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= WORD_RESET;
            dev_rst_q <= 1'b0;
        end else begin
            word_q    <= word_d;
            dev_rst_q <= dev_rst_d;
        end
    end

    // R2: a lone write leaves the preserved bits (other than change bits) alone
    p_keep_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !evt.attach && !evt.detach) |=>
        (((word_q ^ $past(word_q)) & KEEP_MASK & ~CHG_BITS) == '0));

    // R2: a lone write loads the unmasked bits from the data
    p_load_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !evt.attach && !evt.detach) |=>
        ((word_q & ~KEEP_MASK) == ($past(wr_data) & ~KEEP_MASK)));

    // R3: writing 1 to a change bit clears it when no event interferes
    p_w1c_conn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wr_data[B_CONN_CHG] && !evt.attach && !evt.detach) |=>
        !word_q[B_CONN_CHG]);

    // R4: after a reset pulse the stored reset control is set
    p_rst_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst_q |-> word_q[B_PRST]);

    // R4: the reset pulse lasts one cycle
    p_rst_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst_q |=> !dev_rst_q);

    // R5: attach marks the port connected with the reported speed
    p_attach_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt.attach |=> (word_q[B_CONN] && word_q[B_CONN_CHG] &&
                        (word_q[B_LOWSPD] == $past(evt.low_speed))));

    // R6: detach of a connected port flags the disconnect
    p_detach_conn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.detach && !evt.attach && !wr_sel && word_q[B_CONN]) |=>
        (!word_q[B_CONN] && word_q[B_CONN_CHG]));

    // R6: detach of an enabled port disables it and flags the change
    p_detach_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.detach && !evt.attach && !wr_sel && word_q[B_EN]) |=>
        (!word_q[B_EN] && word_q[B_EN_CHG]));

endmodule

// File: rtl/rh_read_mux.sv
// Module: registered read port over all port words. Returns the fixed
// default for unmapped addresses. Holds its output between reads.
module rh_read_mux
    import rh_port_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rd_en,
    input  logic                                addr_hit,
    input  logic [IDX_W-1:0]                    addr_idx,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0]    words,
    output logic [WORD_W-1:0]                   rd_data_q
);

    logic [WORD_W-1:0] sel_word;

    // Pick the addressed word or the default
    always_comb begin
        sel_word = READ_DEFAULT;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr_hit && (addr_idx == IDX_W'(p))) sel_word = words[p];
        end
    end

    // Capture on a read, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd_en) begin
            rd_data_q <= sel_word;
        end
    end

    // R8: unmapped reads return the default word
    p_rd_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr_hit) |=> (rd_data_q == READ_DEFAULT));

    // R9: read data holds when no read is issued
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data_q));

endmodule

// File: rtl/root_port_regs.sv
// Module: root hub port status/control registers for NUM_PORTS ports.
// Assumes a single address shared by reads and writes, one-cycle strobes,
// and synchronous active-low reset.
module root_port_regs
    import rh_port_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 5,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 wr_en,
    input  logic [15:0]          wr_data,
    input  logic                 rd_en,
    output logic [15:0]          rd_data,
    input  logic                 attach_valid,
    input  logic [IDX_W-1:0]     attach_port,
    input  logic                 attach_low_speed,
    input  logic                 detach_valid,
    input  logic [IDX_W-1:0]     detach_port,
    output logic [NUM_PORTS-1:0] dev_reset_req,
    output logic                 resume_req
);

    logic [NUM_PORTS-1:0]             wr_sel;
    logic                             addr_hit;
    logic [IDX_W-1:0]                 addr_idx;
    port_evt_t                        evt [NUM_PORTS];
    logic [NUM_PORTS-1:0][WORD_W-1:0] words;

    // Address decode
    rh_addr_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .addr_hit (addr_hit),
        .addr_idx (addr_idx)
    );

    // Event routing and resume pulse
    rh_event_route #(.NUM_PORTS(NUM_PORTS)) u_evt (
        .clk              (clk),
        .rst_n            (rst_n),
        .attach_valid     (attach_valid),
        .attach_port      (attach_port),
        .attach_low_speed (attach_low_speed),
        .detach_valid     (detach_valid),
        .detach_port      (detach_port),
        .evt              (evt),
        .resume_req       (resume_req)
    );

    // One register cell per port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rh_port_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (wr_sel[p]),
            .wr_data   (wr_data),
            .evt       (evt[p]),
            .word_q    (words[p]),
            .dev_rst_q (dev_reset_req[p])
        );
    end

    // Registered read-back
    rh_read_mux #(.NUM_PORTS(NUM_PORTS)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .addr_hit  (addr_hit),
        .addr_idx  (addr_idx),
        .words     (words),
        .rd_data_q (rd_data)
    );

endmodule

// File: tb/tb_root_port_regs.sv
`timescale 1ns/1ps
module tb_root_port_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        attach_valid = 1'b0;
    logic        attach_port = 1'b0;
    logic        attach_low_speed = 1'b0;
    logic        detach_valid = 1'b0;
    logic        detach_port = 1'b0;
    logic [1:0]  dev_reset_req;
    logic        resume_req;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    // Reference model state
    logic [15:0] m_word [2];
    logic [15:0] m_rd = '0;
    logic [1:0]  m_rst = '0;
    logic        m_resume = 1'b0;

    always #2 clk = ~clk;

    root_port_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .attach_valid(attach_valid), .attach_port(attach_port),
        .attach_low_speed(attach_low_speed), .detach_valid(detach_valid),
        .detach_port(detach_port), .dev_reset_req(dev_reset_req),
        .resume_req(resume_req)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // Behavioural reference: updated at each rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_word[0] = 16'h0080;
            m_word[1] = 16'h0080;
            m_rd = '0;
            m_rst = '0;
            m_resume = 1'b0;
        end else begin
            logic [15:0] v;
            bit hit;
            int idx;
            hit = reg_addr[4] && (reg_addr[3:1] < 2);
            idx = reg_addr[3:1];
            m_resume = attach_valid || detach_valid;
            m_rst = '0;
            if (rd_en) m_rd = hit ? m_word[idx] : 16'hFF7F;
            for (int p = 0; p < 2; p++) begin
                v = m_word[p];
                if (wr_en && hit && idx == p) begin
                    if (wr_data[9] && !v[9]) m_rst[p] = 1'b1;
                    v = (v & 16'h01FB) | (wr_data & 16'hFE04);
                    if (wr_data[1]) v[1] = 1'b0;
                    if (wr_data[3]) v[3] = 1'b0;
                end
                if (attach_valid && attach_port == p) begin
                    v[0] = 1'b1; v[1] = 1'b1; v[8] = attach_low_speed;
                end else if (detach_valid && detach_port == p) begin
                    if (v[0]) begin v[0] = 1'b0; v[1] = 1'b1; end
                    if (v[2]) begin v[2] = 1'b0; v[3] = 1'b1; end
                end
                m_word[p] = v;
            end
        end
    end

    // Compare outputs with the model on every clock, away from the edge
    always @(negedge clk) begin
        if (started) begin
            chk("R9 rd_data vs model", rd_data, m_rd);
            chk("R4 dev_reset_req vs model", 16'(dev_reset_req), 16'(m_rst));
            chk("R7 resume_req vs model", 16'(resume_req), 16'(m_resume));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, rd_data, exp);
    endtask

    task automatic att(input logic p, input logic ls);
        attach_valid = 1'b1; attach_port = p; attach_low_speed = ls;
        @(negedge clk);
        attach_valid = 1'b0;
        chk("R7 resume after attach", 16'(resume_req), 16'h1);
    endtask

    task automatic det(input logic p);
        detach_valid = 1'b1; detach_port = p;
        @(negedge clk);
        detach_valid = 1'b0;
        chk("R7 resume after detach", 16'(resume_req), 16'h1);
    endtask

    // Watchdog
    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 rd_data in reset", rd_data, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dev_reset_req idle", 16'(dev_reset_req), 16'h0);
        chk("R1 resume_req idle", 16'(resume_req), 16'h0);
        rd(5'h10, 16'h0080, "R1 port0 reset word");
        rd(5'h12, 16'h0080, "R1 port1 reset word");

        // R2 / R4: write all ones, reset control rises
        wr(5'h10, 16'hFFFF);
        chk("R4 reset pulse on rise", 16'(dev_reset_req), 16'h1);
        rd(5'h10, 16'hFE84, "R2 masked write");
        wr(5'h10, 16'h0200);
        chk("R4 no pulse when already set", 16'(dev_reset_req), 16'h0);
        rd(5'h10, 16'h0280, "R2 write clears upper bits");
        wr(5'h10, 16'h0000);
        wr(5'h10, 16'h0200);
        chk("R4 pulse after re-arm", 16'(dev_reset_req), 16'h1);
        wr(5'h10, 16'h0000);

        // R5 / R3 / R6 on port 1
        att(1'b1, 1'b1);
        rd(5'h12, 16'h0183, "R5 low-speed attach");
        wr(5'h12, 16'h0004);
        rd(5'h12, 16'h0187, "R2 enable written, change kept");
        wr(5'h12, 16'h0006);
        rd(5'h12, 16'h0185, "R3 connect-change cleared by 1");
        det(1'b1);
        rd(5'h12, 16'h018A, "R6 detach connected enabled port");
        det(1'b1);
        rd(5'h12, 16'h018A, "R6 detach of idle port no change");
        att(1'b0, 1'b0);
        rd(5'h10, 16'h0083, "R5 full-speed attach");

        // R8: unmapped addresses
        wr(5'h14, 16'hFFFF);
        chk("R8 no reset pulse for unmapped write", 16'(dev_reset_req), 16'h0);
        rd(5'h10, 16'h0083, "R8 port0 untouched");
        rd(5'h12, 16'h018A, "R8 port1 untouched");
        rd(5'h14, 16'hFF7F, "R8 out-of-range index default");
        rd(5'h04, 16'hFF7F, "R8 outside port region default");
        rd(5'h13, 16'h018A, "R8 address bit 0 ignored");

        // R10: same-cycle write and attach, attach and detach
        reg_addr = 5'h10; wr_data = 16'h0002; wr_en = 1'b1;
        attach_valid = 1'b1; attach_port = 1'b0; attach_low_speed = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; attach_valid = 1'b0;
        rd(5'h10, 16'h0183, "R10 attach over write");
        attach_valid = 1'b1; attach_port = 1'b1; attach_low_speed = 1'b0;
        detach_valid = 1'b1; detach_port = 1'b1;
        @(negedge clk);
        attach_valid = 1'b0; detach_valid = 1'b0;
        rd(5'h12, 16'h008B, "R10 attach wins over detach");

        // R9: read returns pre-write value, then holds
        reg_addr = 5'h12; wr_data = 16'h000A; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9 read before same-cycle write", rd_data, 16'h008B);
        rd(5'h12, 16'h0081, "R3 both change bits cleared");
        wr(5'h10, 16'h0000);
        chk("R9 rd_data holds", rd_data, 16'h0081);

        // Random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            reg_addr = ($urandom_range(0, 7) == 0) ? 5'($urandom) : {1'b1, 3'($urandom_range(0, 2)), 1'($urandom)};
            wr_en = ($urandom_range(0, 2) == 0);
            wr_data = 16'($urandom);
            rd_en = ($urandom_range(0, 1) == 0);
            attach_valid = ($urandom_range(0, 5) == 0);
            attach_port = 1'($urandom);
            attach_low_speed = 1'($urandom);
            detach_valid = ($urandom_range(0, 5) == 0);
            detach_port = 1'($urandom);
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0; attach_valid = 1'b0; detach_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule